// File: doc/BRIEF.md
# Serial Transmitter with Line Break and Inter-Frame Guard

This block turns bytes into asynchronous serial frames on a single output line. A host loads one byte at a time into a one-entry holding register. The byte then moves into a shift register and leaves as a start bit, eight data bits (least significant first), an optional even-parity bit and a stop bit. An external divider supplies a one-cycle baud enable. Every bit boundary falls on that enable, so one bit period is the interval between two enables.

The host can also hold the line low as a break. A start-break command does not cut into traffic. Any byte already accepted into the holding register is sent in full, including its guard time, before the line goes low. A stop-break command ends the break. The line then stays at logic 1 for a fixed twelve-bit mark before the next frame may begin. A programmable guard count adds that many idle bit periods after each frame. Two flags report whether a new byte can be accepted and whether the transmitter has gone fully quiet.

Top module: `uart_brk_tx`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. After release, `txd` is 1 and `tx_ready` and `tx_empty` are both 1.
- R2: A frame is one period at 0, then `wr_data` bit 0 through bit 7 in that order, then an even-parity bit (XOR of the eight data bits) only when `parity_en` is 1, then one period at 1. Each bit lasts exactly from one `baud_tick` to the next.
- R3: `tx_ready` is 1 exactly when the holding register is empty, and it falls in the cycle after an accepted write. A write pulsed while `tx_ready` is 0 is dropped, and that byte never appears on `txd`.
- R4: With `guard_bits` at 0, a byte already waiting in the holding register starts its start bit in the period right after the previous stop bit, with no idle bit in between.
- R5: With `guard_bits` = G > 0, exactly G periods at 1 follow each stop bit before a waiting byte starts. A G of 12 gives the same spacing as the mark that follows a break.
- R6: A start-break pulse that arrives while a byte sits in the holding register lets that byte finish, with its guard periods, before `txd` goes low for the break.
- R7: Once the break has begun, `txd` stays 0 until a stop-break has been seen and the next `baud_tick` arrives.
- R8: After a stop-break, `txd` is 1 for exactly 12 periods. A byte written during the break is held back and starts right after those 12 periods.
- R9: A start-break pulse while a break is already waiting or active has no effect. A stop-break pulse while the line is not in a break has no effect.
- R10: `tx_empty` is 1 only when the holding register is empty, no frame, guard, break or mark is in progress, and no break is waiting. It is 0 from the cycle after a write or an accepted start-break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable marking each bit boundary |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Byte to transmit |
| parity_en | input | 1 | 1 adds an even-parity bit to each frame |
| guard_bits | input | 8 | Idle periods inserted after each stop bit; 0 disables |
| brk_start | input | 1 | Pulse that requests a line break |
| brk_stop | input | 1 | Pulse that ends an active break |
| txd | output | 1 | Serial output line, idle high |
| tx_ready | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Nothing held, sending, waiting or in break |

## Verification
The sequencer state feeds `txd` directly, so a wrong state shows up within one bit period as a misplaced edge. The bench decodes the line, and such an edge appears there as a changed byte, a bad parity or stop bit, or a gap of the wrong length. Mistakes in the break logic are different: a break taken too early, a second break, or a missing mark period only shows up after the current frame ends. The scoreboard catches these because it checks frame order and the exact count of idle periods between frames. A flag that disagrees with the holding register or with the sequencer can be seen one cycle after the write or command that should have moved it.

// File: rtl/uart_brk_pkg.sv
// Shared types for the break-capable serial transmitter.
package uart_brk_pkg;

    // Sequencer states; each one lasts a whole number of bit periods.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_GUARD,
        ST_BREAK,
        ST_MARK
    } txs_e;

endpackage

// File: rtl/ubt_hold.sv
// One-entry holding register.
// Accepts a byte when empty and drops writes when full. It also keeps a tag
// that says whether the byte arrived after a break was requested. Assumes
// that take is raised only while full.
module ubt_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          tag_in,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data,
    output logic          tag
);

    // Load on a write to an empty entry; release when the sequencer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
            tag  <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
            tag  <= tag_in;
        end
    end

    // R3: a write into a full entry leaves the stored byte alone
    a_r3_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !take) |=> (full && $stable(data)));

    // R3: the sequencer only removes a byte that is present
    a_r3_take_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full);

endmodule

// File: rtl/ubt_brkctl.sv
// Break command latch.
// Records a start-break request until the sequencer acts on it. It also
// records a stop-break seen during an active break until the mark begins.
// Repeated or out-of-place commands are dropped. Assumes the command pulses
// are synchronous to clk.
module ubt_brkctl (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_start,
    input  logic brk_stop,
    input  logic in_break,
    input  logic break_enter,
    input  logic mark_enter,
    output logic brk_pend,
    output logic stop_req
);

    // Hold a start request until the line actually goes into break.
    always_ff @(posedge clk) begin
        if (!rst_n)
            brk_pend <= 1'b0;
        else if (break_enter)
            brk_pend <= 1'b0;
        else if (brk_start && !in_break)
            brk_pend <= 1'b1;
    end

    // Hold a stop request, valid only inside a break, until the mark starts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stop_req <= 1'b0;
        else if (mark_enter)
            stop_req <= 1'b0;
        else if (brk_stop && in_break)
            stop_req <= 1'b1;
    end

    // R9: a waiting request never coexists with an active break
    a_r9_pend_not_in_break: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pend |-> !in_break);

    // R9: a stop request only exists while the line is in break
    a_r9_stop_only_in_break: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> in_break);

endmodule

// File: rtl/ubt_seq.sv
// Frame, guard and break sequencer with shift register.
// It moves between states only on baud_tick. When a period ends it picks
// what comes next. A byte accepted before the break request goes first,
// then a waiting break, then any other byte. Assumes guard_bits and
// parity_en change only while the line is idle.
module ubt_seq
    import uart_brk_pkg::*;
#(
    parameter int DW        = 8,
    parameter int GW        = 8,
    parameter int MARK_BITS = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          parity_en,
    input  logic [GW-1:0] guard_bits,
    input  logic          hold_full,
    input  logic          hold_late,
    input  logic [DW-1:0] hold_data,
    input  logic          brk_pend,
    input  logic          stop_req,
    output logic          take,
    output logic          txd,
    output logic          is_idle,
    output logic          in_break,
    output logic          break_enter,
    output logic          mark_enter
);

    localparam int MW  = $clog2(MARK_BITS + 1);
    localparam int IW  = $clog2(DW);
    localparam int CW0 = (GW > MW) ? GW : MW;
    localparam int CW  = (CW0 > IW) ? CW0 : IW;

    txs_e          state, nxt, pick;
    logic [CW-1:0] cnt, cnt_nxt;
    logic [DW-1:0] sh;
    logic          par_bit;

    // Choose what follows the end of a period: early byte, break, later byte.
    always_comb begin
        if (hold_full && !hold_late)
            pick = ST_START;
        else if (brk_pend)
            pick = ST_BREAK;
        else if (hold_full)
            pick = ST_START;
        else
            pick = ST_IDLE;
    end

    // Next state and period counter, advanced only on a baud tick.
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        if (baud_tick) begin
            case (state)
                ST_IDLE:  nxt = pick;
                ST_START: begin
                    nxt     = ST_DATA;
                    cnt_nxt = CW'(DW - 1);
                end
                ST_DATA: begin
                    if (cnt == '0)
                        nxt = parity_en ? ST_PAR : ST_STOP;
                    else
                        cnt_nxt = cnt - CW'(1);
                end
                ST_PAR:   nxt = ST_STOP;
                ST_STOP: begin
                    if (guard_bits != '0) begin
                        nxt     = ST_GUARD;
                        cnt_nxt = CW'(guard_bits) - CW'(1);
                    end else begin
                        nxt = pick;
                    end
                end
                ST_GUARD: begin
                    if (cnt == '0)
                        nxt = pick;
                    else
                        cnt_nxt = cnt - CW'(1);
                end
                ST_BREAK: begin
                    if (stop_req) begin
                        nxt     = ST_MARK;
                        cnt_nxt = CW'(MARK_BITS - 1);
                    end
                end
                ST_MARK: begin
                    if (cnt == '0)
                        nxt = pick;
                    else
                        cnt_nxt = cnt - CW'(1);
                end
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    assign take        = (nxt == ST_START) && (state != ST_START);
    assign break_enter = (nxt == ST_BREAK) && (state != ST_BREAK);
    assign mark_enter  = (nxt == ST_MARK) && (state != ST_MARK);
    assign is_idle     = (state == ST_IDLE);
    assign in_break    = (state == ST_BREAK);

    // Shift register and parity: load on take, shift once per data period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            par_bit <= 1'b0;
        end else if (take) begin
            sh      <= hold_data;
            par_bit <= ^hold_data;
        end else if (baud_tick && state == ST_DATA) begin
            sh <= sh >> 1;
        end
    end

    // Line level for the current state.
    always_comb begin
        case (state)
            ST_START, ST_BREAK: txd = 1'b0;
            ST_DATA:            txd = sh[0];
            ST_PAR:             txd = par_bit;
            default:            txd = 1'b1;
        endcase
    end

    // R2: state moves only on bit boundaries
    a_r2_tick_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(state));

    // R7: break persists until a stop request has been recorded
    a_r7_break_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BREAK && !stop_req) |=> (state == ST_BREAK));

    // R8: mark lasts until its final counted period ends on a tick
    a_r8_mark_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MARK && !(baud_tick && cnt == '0)) |=> (state == ST_MARK));

endmodule

// File: rtl/uart_brk_tx.sv
// Break-capable asynchronous serial transmitter (top).
// Wires the holding register, the break command latch and the sequencer
// together, and derives the two status flags. Assumes baud_tick is a
// single-cycle enable from an external divider.
module uart_brk_tx #(
    parameter int DW        = 8,
    parameter int GW        = 8,
    parameter int MARK_BITS = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          parity_en,
    input  logic [GW-1:0] guard_bits,
    input  logic          brk_start,
    input  logic          brk_stop,
    output logic          txd,
    output logic          tx_ready,
    output logic          tx_empty
);

    logic          hold_full, hold_late, take;
    logic [DW-1:0] hold_data;
    logic          brk_pend, stop_req;
    logic          is_idle, in_break, break_enter, mark_enter;

    ubt_hold #(.DW(DW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .tag_in  (brk_pend || in_break),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data),
        .tag     (hold_late)
    );

    ubt_brkctl u_brk (
        .clk         (clk),
        .rst_n       (rst_n),
        .brk_start   (brk_start),
        .brk_stop    (brk_stop),
        .in_break    (in_break),
        .break_enter (break_enter),
        .mark_enter  (mark_enter),
        .brk_pend    (brk_pend),
        .stop_req    (stop_req)
    );

    ubt_seq #(.DW(DW), .GW(GW), .MARK_BITS(MARK_BITS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud_tick   (baud_tick),
        .parity_en   (parity_en),
        .guard_bits  (guard_bits),
        .hold_full   (hold_full),
        .hold_late   (hold_late),
        .hold_data   (hold_data),
        .brk_pend    (brk_pend),
        .stop_req    (stop_req),
        .take        (take),
        .txd         (txd),
        .is_idle     (is_idle),
        .in_break    (in_break),
        .break_enter (break_enter),
        .mark_enter  (mark_enter)
    );

    // Status flags from holding register, sequencer and break latch.
    assign tx_ready = !hold_full;
    assign tx_empty = !hold_full && is_idle && !brk_pend;

    // R10: a fully quiet transmitter always shows an idle line
    a_r10_empty_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);

    // R6: a byte accepted before the break request is never skipped by it
    a_r6_char_before_break: assert property (@(posedge clk) disable iff (!rst_n)
        break_enter |-> !(hold_full && !hold_late));

endmodule

// File: tb/uart_brk_tx_test.sv
// Scoreboard bench: the driver queues expected frames, and a line monitor
// decodes txd and compares each frame and the idle gap after it.
module uart_brk_tx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       parity_en = 1'b0;
    logic [7:0] guard_bits = '0;
    logic       brk_start = 1'b0;
    logic       brk_stop = 1'b0;
    logic       txd, tx_ready, tx_empty;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        bit         brk;
        logic [7:0] d;
        int         gap;
        string      tag;
    } item_t;

    item_t exp_q[$];

    uart_brk_tx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .parity_en  (parity_en),
        .guard_bits (guard_bits),
        .brk_start  (brk_start),
        .brk_stop   (brk_stop),
        .txd        (txd),
        .tx_ready   (tx_ready),
        .tx_empty   (tx_empty)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Baud enable: one cycle high in every four.
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    // ---------------- line monitor ----------------
    int    m_st = 0;
    int    gap_cnt = 0;
    int    prev_exp = -1;
    string prev_tag = "";
    logic  fr[0:9];
    int    nb = 0;

    task automatic pop_cmp(input bit is_brk, input logic [7:0] d);
        item_t it;
        if (exp_q.size() == 0) begin
            check(1'b0, "R3 unexpected frame", int'(d), -1);
            prev_exp = -1;
        end else begin
            it = exp_q.pop_front();
            check(is_brk == it.brk, {it.tag, " frame kind"}, int'(is_brk), int'(it.brk));
            if (!it.brk)
                check(d == it.d, {it.tag, " R2 data"}, int'(d), int'(it.d));
            prev_exp = it.gap;
            prev_tag = it.tag;
        end
    endtask

    task automatic mon_bit(input logic b);
        int         need;
        logic [7:0] d;
        bit         allz;
        need = parity_en ? 10 : 9;
        case (m_st)
            0: begin
                if (b) gap_cnt++;
                else begin
                    if (prev_exp >= 0)
                        check(gap_cnt == prev_exp, {prev_tag, " gap"}, gap_cnt, prev_exp);
                    m_st = 1;
                    nb = 0;
                end
            end
            1: begin
                fr[nb] = b;
                nb++;
                if (nb == need) begin
                    for (int i = 0; i < 8; i++) d[i] = fr[i];
                    allz = 1'b1;
                    for (int i = 0; i < need; i++) if (fr[i]) allz = 1'b0;
                    if (fr[need-1]) begin
                        if (parity_en)
                            check(fr[8] == ^d, "R2 parity", int'(fr[8]), int'(^d));
                        pop_cmp(1'b0, d);
                        m_st = 0;
                        gap_cnt = 0;
                    end else if (allz) begin
                        m_st = 2;
                    end else begin
                        check(1'b0, "R2 stop bit", 0, 1);
                        m_st = 0;
                        gap_cnt = 0;
                        prev_exp = -1;
                    end
                end
            end
            default: begin
                if (b) begin
                    pop_cmp(1'b1, 8'h00);
                    m_st = 0;
                    gap_cnt = 1;
                end
            end
        endcase
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && baud_tick) begin
                @(negedge clk);
                mon_bit(txd);
            end
        end
    end

    // ---------------- driver ----------------
    task automatic push(input bit b, input logic [7:0] d, input int gap, input string tag);
        item_t it;
        it.brk = b;
        it.d   = d;
        it.gap = gap;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic wait_ready();
        while (!tx_ready) @(negedge clk);
    endtask

    task automatic put(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic pulse_start();
        brk_start = 1'b1;
        @(negedge clk);
        brk_start = 1'b0;
    endtask

    task automatic pulse_stop();
        brk_stop = 1'b1;
        @(negedge clk);
        brk_stop = 1'b0;
    endtask

    task automatic drain(input string tag);
        while (!tx_empty) @(negedge clk);
        repeat (16) @(negedge clk);
        check(exp_q.size() == 0, {tag, " all frames seen"}, exp_q.size(), 0);
        check(txd == 1'b1, {tag, " line idle"}, int'(txd), 1);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd", int'(txd), 1);
        check(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);
        check(tx_empty == 1'b1, "R1 tx_empty", int'(tx_empty), 1);

        // R4 back-to-back, no parity, no guard; R3 dropped write
        parity_en = 1'b0;
        guard_bits = 8'd0;
        push(1'b0, 8'hA5, 0, "R4");
        push(1'b0, 8'h3C, 0, "R4");
        push(1'b0, 8'hFF, -1, "R4");
        put(8'hA5);
        check(tx_ready == 1'b0, "R3 ready falls", int'(tx_ready), 0);
        check(tx_empty == 1'b0, "R10 busy after write", int'(tx_empty), 0);
        put(8'h77);  // dropped: holding register full
        wait_ready();
        put(8'h3C);
        wait_ready();
        put(8'hFF);
        drain("R4");
        check(tx_ready == 1'b1 && tx_empty == 1'b1, "R10 quiet", int'(tx_empty), 1);

        // R5 guard of 3 with even parity
        parity_en = 1'b1;
        guard_bits = 8'd3;
        push(1'b0, 8'h01, 3, "R5");
        push(1'b0, 8'h03, 3, "R5");
        push(1'b0, 8'h80, -1, "R5");
        put(8'h01);
        wait_ready();
        put(8'h03);
        wait_ready();
        put(8'h80);
        drain("R5");

        // R5 guard of 12 equals the mark spacing
        parity_en = 1'b0;
        guard_bits = 8'd12;
        push(1'b0, 8'h5E, 12, "R5 g12");
        push(1'b0, 8'hE7, -1, "R5 g12");
        put(8'h5E);
        wait_ready();
        put(8'hE7);
        drain("R5 g12");

        // R6/R7/R8/R9 break behind a held byte
        guard_bits = 8'd0;
        push(1'b0, 8'h5A, 0, "R6");
        push(1'b0, 8'hC3, 0, "R6");
        push(1'b1, 8'h00, 12, "R8");
        push(1'b0, 8'h42, -1, "R8");
        put(8'h5A);
        wait_ready();
        put(8'hC3);
        pulse_start();
        check(tx_empty == 1'b0, "R10 break waiting", int'(tx_empty), 0);
        while (m_st != 2) @(negedge clk);
        check(txd == 1'b0, "R7 line low", int'(txd), 0);
        put(8'h42);
        check(tx_ready == 1'b0, "R8 byte held in break", int'(tx_ready), 0);
        pulse_start();  // R9: ignored, break already active
        for (int k = 0; k < 20; k++) begin
            repeat (4) @(negedge clk);
            check(txd == 1'b0, "R7 held low", int'(txd), 0);
        end
        check(tx_empty == 1'b0, "R10 in break", int'(tx_empty), 0);
        pulse_stop();
        drain("R8");

        // R9 stop-break with no break active
        pulse_stop();
        repeat (40) @(negedge clk);
        check(txd == 1'b1, "R9 stop ignored line", int'(txd), 1);
        check(tx_empty == 1'b1, "R9 stop ignored empty", int'(tx_empty), 1);
        push(1'b0, 8'h99, -1, "R9");
        put(8'h99);
        drain("R9");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule